// File: doc/BRIEF.md
# Adaptive OTP Byte Burner

This block writes a range of bytes into an 8-bit wide one-time-programmable memory with a 15-bit address, one location at a time. For each location it fetches the byte from an image source, then drives address and data onto the memory. It lowers the active-low chip enable for one program pulse, releases the data bus and reads the cell back with the output enable low. If the read byte differs from the intended byte, it tries again, up to a fixed attempt limit. Once the byte reads back correctly, it applies one further over-burn pulse whose length is three times the number of attempts, in program-pulse units. It then moves on to the next address.

A controller starts a job by giving a first and a last address and pulsing a start input. The block reports completion or, if a cell never verifies within the attempt limit, it stops and reports the address and the number of attempts made. All timing is counted in clock ticks. The ticks come from a clock-frequency parameter and from the lengths, in microseconds, of the program pulse unit, the setup/hold window and the read access window. The supply rails and their sequencing are outside this block.

Top module: `otp_burn_seq`

## Requirements
- R1: After reset, busy_o, done_o, fail_o, img_req_o and mem_drive_o are 0, and mem_ce_n_o and mem_oe_n_o are 1. The same memory pin state holds whenever the block is idle.
- R2: start_i is accepted only while busy_o is 0. On acceptance, busy_o is 1 in the next cycle and done_o and fail_o are cleared. A start pulse, or a change of the address inputs, while busy_o is 1 has no effect on the job in progress.
- R3: For each location the block raises img_req_o with img_addr_o equal to the location exactly once. It captures img_data_i in the cycle img_vld_i is 1, and waits any number of cycles for it. No program pulse occurs while a request is open.
- R4: A normal program pulse holds mem_ce_n_o low for exactly one pulse unit (MS ticks). During the pulse mem_drive_o is 1, mem_oe_n_o is 1 and mem_data_o carries the image byte.
- R5: mem_addr_o and mem_data_o are driven and unchanged for at least SU ticks before mem_ce_n_o falls, throughout the pulse, and for at least SU ticks after it rises.
- R6: After each normal pulse the bus is released and mem_oe_n_o is low for exactly ACC ticks with mem_ce_n_o high. mem_data_i is compared with the image byte in the last of those cycles. mem_oe_n_o then stays high with the bus released for at least ACC ticks before the bus is driven again.
- R7: On a mismatch the fetch is not repeated and the pulse/verify cycle is run again. At most MAX_TRIES normal pulses are issued per location.
- R8: When the byte verifies after X normal pulses, one further pulse of exactly 3·X·MS ticks follows with the same address and data, and no further verify follows it.
- R9: Locations are processed in increasing order from the first to the latched last address. After the last over-burn pulse, busy_o falls and done_o rises, and done_o stays 1 until the next accepted start. done_o and fail_o are never both 1.
- R10: If the verify after pulse number MAX_TRIES still mismatches, the job stops and no further location is requested. fail_o rises and stays 1, fail_addr_o holds the failing address and fail_tries_o equals MAX_TRIES.
- R11: mem_ce_n_o and mem_oe_n_o are never low together, and mem_drive_o is never 1 while mem_oe_n_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, honoured only when idle |
| first_addr_i | input | ADDR_W (15) | First location of the job |
| last_addr_i | input | ADDR_W (15) | Last location of the job |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | Last job finished with every byte verified |
| fail_o | output | 1 | Last job stopped on a cell that never verified |
| fail_addr_o | output | ADDR_W (15) | Address of the failing cell |
| fail_tries_o | output | TRY_W (5) | Attempts made on the failing cell |
| img_req_o | output | 1 | Image byte request open |
| img_addr_o | output | ADDR_W (15) | Address of the requested image byte |
| img_vld_i | input | 1 | Image byte valid; captured while img_req_o is 1 |
| img_data_i | input | DATA_W (8) | Image byte |
| mem_addr_o | output | ADDR_W (15) | Memory address pins |
| mem_data_o | output | DATA_W (8) | Data driven towards the memory |
| mem_drive_o | output | 1 | Output enable of the data bus driver |
| mem_data_i | input | DATA_W (8) | Data read from the memory bus |
| mem_ce_n_o | output | 1 | Active-low chip enable / program strobe |
| mem_oe_n_o | output | 1 | Active-low output enable (verify read) |

## Verification
The bench builds the block with a 1000 kHz tick rate, a 10 µs pulse unit and a 2 µs setup and access window. This gives program pulses of 10 ticks, over-burn pulses of up to 750 ticks and windows of 2 ticks. The attempt limit keeps its full value of 25, so a cell that needs exactly 25 pulses (the longest over-burn) and one that never verifies can both be reached within a short run. A memory model counts pulses per address and returns the right byte only after a per-address number of pulses. Image-source stalls and a restart attempt in mid-job show the fetch wait and the latched range.

// File: rtl/otp_burn_pkg.sv
package otp_burn_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_SETUP,
    ST_PROG,
    ST_HOLD,
    ST_READ,
    ST_RECOVER,
    ST_ADVANCE
  } burn_state_e;

  // Round a time in microseconds up to whole clock ticks.
  function automatic int unsigned us_to_ticks(int unsigned us, int unsigned clk_khz);
    longint unsigned prod;
    prod = longint'(us) * longint'(clk_khz);
    return int'((prod + 64'd999) / 64'd1000);
  endfunction

  // Length of the over-burn pulse after a byte verified on attempt number tries.
  function automatic int unsigned overburn_ticks(int unsigned tries, int unsigned unit_ticks);
    return 3 * tries * unit_ticks;
  endfunction

endpackage

// File: rtl/otp_tick_timer.sv
module otp_tick_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] len_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  // Loading len makes zero_o rise len cycles later, so a state entered
  // with a load lasts exactly len cycles.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= len_i - W'(1);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - W'(1);
    end
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/otp_try_counter.sv
module otp_try_counter #(
  parameter int MAX_TRIES = 25,
  parameter int W         = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] count_o,
  output logic         limit_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (inc_i && (cnt_q != W'(MAX_TRIES))) begin
      cnt_q <= cnt_q + W'(1);
    end
  end

  assign count_o = cnt_q;
  assign limit_o = (cnt_q == W'(MAX_TRIES));
endmodule

// File: rtl/otp_addr_walker.sv
module otp_addr_walker #(
  parameter int AW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [AW-1:0] first_i,
  input  logic [AW-1:0] last_i,
  input  logic          step_i,
  output logic [AW-1:0] addr_o,
  output logic          at_last_o
);
  logic [AW-1:0] addr_q;
  logic [AW-1:0] last_q;

  // The range is captured once per job; later input changes are ignored.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      last_q <= '0;
    end else if (load_i) begin
      addr_q <= first_i;
      last_q <= last_i;
    end else if (step_i) begin
      addr_q <= addr_q + AW'(1);
    end
  end

  assign addr_o    = addr_q;
  assign at_last_o = (addr_q == last_q);
endmodule

// File: rtl/otp_burn_seq.sv
module otp_burn_seq
  import otp_burn_pkg::*;
#(
  parameter int ADDR_W    = 15,
  parameter int DATA_W    = 8,
  parameter int CLK_KHZ   = 16000,
  parameter int UNIT_US   = 1000,
  parameter int SETUP_US  = 2,
  parameter int ACCESS_US = 1,
  parameter int MAX_TRIES = 25,
  localparam int TRY_W    = $clog2(MAX_TRIES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] first_addr_i,
  input  logic [ADDR_W-1:0] last_addr_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              fail_o,
  output logic [ADDR_W-1:0] fail_addr_o,
  output logic [TRY_W-1:0]  fail_tries_o,
  output logic              img_req_o,
  output logic [ADDR_W-1:0] img_addr_o,
  input  logic              img_vld_i,
  input  logic [DATA_W-1:0] img_data_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_data_o,
  output logic              mem_drive_o,
  input  logic [DATA_W-1:0] mem_data_i,
  output logic              mem_ce_n_o,
  output logic              mem_oe_n_o
);
  localparam int unsigned MS_TICKS  = us_to_ticks(UNIT_US, CLK_KHZ);
  localparam int unsigned SU_TICKS  = us_to_ticks(SETUP_US, CLK_KHZ);
  localparam int unsigned ACC_TICKS = us_to_ticks(ACCESS_US, CLK_KHZ);
  localparam int unsigned LONGEST   = overburn_ticks(MAX_TRIES, MS_TICKS);
  localparam int          TMR_W     = $clog2(LONGEST + 1);

  burn_state_e state_q, state_d;

  logic [DATA_W-1:0] data_q;
  logic              match_q;
  logic              extra_q;
  logic              done_q, fail_q;
  logic [ADDR_W-1:0] fail_addr_q;
  logic [TRY_W-1:0]  fail_tries_q;

  logic              tmr_load;
  logic [TMR_W-1:0]  tmr_len;
  logic              tmr_zero;
  logic [TRY_W-1:0]  tries;
  logic              try_limit;
  logic [ADDR_W-1:0] cur_addr;
  logic              at_last;

  // Named internal events, shared by the next-state logic, the registers
  // and the bound checker.
  logic ev_accept;       // start taken while idle
  logic ev_capture;      // image byte captured
  logic ev_pulse_start;  // normal program pulse begins
  logic ev_burn_start;   // over-burn pulse begins
  logic ev_sample;       // read-back compared
  logic ev_pass;         // verify succeeded, go to over-burn
  logic ev_retry;        // verify failed, another attempt allowed
  logic ev_give_up;      // verify failed on the last allowed attempt
  logic ev_step;         // move to the next location
  logic ev_finish;       // last location completed

  logic [TMR_W-1:0] burn_len;
  assign burn_len = TMR_W'(overburn_ticks(int'(tries), MS_TICKS));

  assign ev_accept      = (state_q == ST_IDLE) && start_i;
  assign ev_capture     = (state_q == ST_FETCH) && img_vld_i;
  assign ev_pulse_start = (state_q == ST_SETUP) && tmr_zero && !extra_q;
  assign ev_burn_start  = (state_q == ST_SETUP) && tmr_zero && extra_q;
  assign ev_sample      = (state_q == ST_READ) && tmr_zero;
  assign ev_pass        = (state_q == ST_RECOVER) && tmr_zero && match_q;
  assign ev_retry       = (state_q == ST_RECOVER) && tmr_zero && !match_q && !try_limit;
  assign ev_give_up     = (state_q == ST_RECOVER) && tmr_zero && !match_q && try_limit;
  assign ev_step        = (state_q == ST_ADVANCE) && !at_last;
  assign ev_finish      = (state_q == ST_ADVANCE) && at_last;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_len  = TMR_W'(SU_TICKS);
    unique case (state_q)
      ST_IDLE: begin
        if (ev_accept) state_d = ST_FETCH;
      end
      ST_FETCH: begin
        if (ev_capture) begin
          tmr_load = 1'b1;
          tmr_len  = TMR_W'(SU_TICKS);
          state_d  = ST_SETUP;
        end
      end
      ST_SETUP: begin
        if (tmr_zero) begin
          tmr_load = 1'b1;
          tmr_len  = extra_q ? burn_len : TMR_W'(MS_TICKS);
          state_d  = ST_PROG;
        end
      end
      ST_PROG: begin
        if (tmr_zero) begin
          tmr_load = 1'b1;
          tmr_len  = TMR_W'(SU_TICKS);
          state_d  = ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (tmr_zero) begin
          if (extra_q) begin
            state_d = ST_ADVANCE;
          end else begin
            tmr_load = 1'b1;
            tmr_len  = TMR_W'(ACC_TICKS);
            state_d  = ST_READ;
          end
        end
      end
      ST_READ: begin
        if (tmr_zero) begin
          tmr_load = 1'b1;
          tmr_len  = TMR_W'(ACC_TICKS);
          state_d  = ST_RECOVER;
        end
      end
      ST_RECOVER: begin
        if (ev_pass || ev_retry) begin
          tmr_load = 1'b1;
          tmr_len  = TMR_W'(SU_TICKS);
          state_d  = ST_SETUP;
        end else if (ev_give_up) begin
          state_d = ST_IDLE;
        end
      end
      ST_ADVANCE: begin
        state_d = ev_finish ? ST_IDLE : ST_FETCH;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      data_q       <= '0;
      match_q      <= 1'b0;
      extra_q      <= 1'b0;
      done_q       <= 1'b0;
      fail_q       <= 1'b0;
      fail_addr_q  <= '0;
      fail_tries_q <= '0;
    end else begin
      state_q <= state_d;
      if (ev_capture) begin
        data_q  <= img_data_i;
        extra_q <= 1'b0;
      end else if (ev_pass) begin
        extra_q <= 1'b1;
      end
      if (ev_sample) match_q <= (mem_data_i == data_q);
      if (ev_accept) begin
        done_q <= 1'b0;
        fail_q <= 1'b0;
      end
      if (ev_finish) done_q <= 1'b1;
      if (ev_give_up) begin
        fail_q       <= 1'b1;
        fail_addr_q  <= cur_addr;
        fail_tries_q <= tries;
      end
    end
  end

  otp_tick_timer #(.W(TMR_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (tmr_load),
    .len_i  (tmr_len),
    .zero_o (tmr_zero)
  );

  otp_try_counter #(.MAX_TRIES(MAX_TRIES), .W(TRY_W)) u_tries (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (ev_capture),
    .inc_i   (ev_pulse_start),
    .count_o (tries),
    .limit_o (try_limit)
  );

  otp_addr_walker #(.AW(ADDR_W)) u_walker (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (ev_accept),
    .first_i   (first_addr_i),
    .last_i    (last_addr_i),
    .step_i    (ev_step),
    .addr_o    (cur_addr),
    .at_last_o (at_last)
  );

  assign busy_o       = (state_q != ST_IDLE);
  assign done_o       = done_q;
  assign fail_o       = fail_q;
  assign fail_addr_o  = fail_addr_q;
  assign fail_tries_o = fail_tries_q;
  assign img_req_o    = (state_q == ST_FETCH);
  assign img_addr_o   = cur_addr;
  assign mem_addr_o   = cur_addr;
  assign mem_data_o   = data_q;
  assign mem_drive_o  = (state_q == ST_SETUP) || (state_q == ST_PROG) || (state_q == ST_HOLD);
  assign mem_ce_n_o   = (state_q != ST_PROG);
  assign mem_oe_n_o   = (state_q != ST_READ);
endmodule

// File: rtl/otp_burn_seq_chk.sv
module otp_burn_seq_chk #(
  parameter int AW          = 15,
  parameter int DW          = 8,
  parameter int TRY_W       = 5,
  parameter int MAX_TRIES   = 25,
  parameter int SETUP_TICKS = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ce_n,
  input logic          oe_n,
  input logic          drive,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] data,
  input logic          done,
  input logic          fail,
  input logic [TRY_W-1:0] fail_tries,
  input logic          ev_pulse_start,
  input logic [TRY_W-1:0] tries
);
  // Consecutive samples for which drive, address and data were unchanged.
  logic [15:0]   stab_q;
  logic          drive_p;
  logic [AW-1:0] addr_p;
  logic [DW-1:0] data_p;
  logic          same;

  assign same = drive && drive_p && (addr == addr_p) && (data == data_p);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stab_q  <= '0;
      drive_p <= 1'b0;
      addr_p  <= '0;
      data_p  <= '0;
    end else begin
      drive_p <= drive;
      addr_p  <= addr;
      data_p  <= data;
      if (!drive)               stab_q <= '0;
      else if (!same)           stab_q <= 16'd1;
      else if (stab_q != 16'hFFFF) stab_q <= stab_q + 16'd1;
    end
  end

  assert_ce_oe_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ce_n && !oe_n));

  assert_bus_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> !drive);

  assert_pulse_driven_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_n |-> (drive && oe_n));

  assert_pulse_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !$past(ce_n)) |-> ($stable(addr) && $stable(data)));

  assert_setup_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ce_n) |-> (stab_q >= 16'(SETUP_TICKS)));

  assert_try_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pulse_start |-> (tries < TRY_W'(MAX_TRIES)));

  assert_fail_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail) |-> (fail_tries == TRY_W'(MAX_TRIES)));

  assert_done_fail_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail));
endmodule

bind otp_burn_seq otp_burn_seq_chk #(
  .AW          (ADDR_W),
  .DW          (DATA_W),
  .TRY_W       (TRY_W),
  .MAX_TRIES   (MAX_TRIES),
  .SETUP_TICKS (SU_TICKS)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .ce_n           (mem_ce_n_o),
  .oe_n           (mem_oe_n_o),
  .drive          (mem_drive_o),
  .addr           (mem_addr_o),
  .data           (mem_data_o),
  .done           (done_o),
  .fail           (fail_o),
  .fail_tries     (fail_tries_o),
  .ev_pulse_start (ev_pulse_start),
  .tries          (tries)
);

// File: tb/otp_burn_seq_test.sv
module otp_burn_seq_test;
  localparam int AW    = 15;
  localparam int DW    = 8;
  localparam int KHZ   = 1000;
  localparam int UNIT  = 10;
  localparam int SU    = 2;
  localparam int ACC   = 2;
  localparam int MAXT  = 25;
  localparam int K_MS  = UNIT;
  localparam int TRW   = $clog2(MAXT + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [AW-1:0] first_addr_i = '0;
  logic [AW-1:0] last_addr_i = '0;
  logic img_vld_i = 1'b0;
  logic [DW-1:0] img_data_i = '0;
  logic [DW-1:0] mem_data_i = '0;
  logic busy_o, done_o, fail_o, img_req_o, mem_drive_o, mem_ce_n_o, mem_oe_n_o;
  logic [AW-1:0] fail_addr_o, img_addr_o, mem_addr_o;
  logic [TRW-1:0] fail_tries_o;
  logic [DW-1:0] mem_data_o;

  always #10 clk = ~clk;

  otp_burn_seq #(
    .ADDR_W(AW), .DATA_W(DW), .CLK_KHZ(KHZ), .UNIT_US(UNIT),
    .SETUP_US(SU), .ACCESS_US(ACC), .MAX_TRIES(MAXT)
  ) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .first_addr_i(first_addr_i), .last_addr_i(last_addr_i),
    .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o),
    .fail_addr_o(fail_addr_o), .fail_tries_o(fail_tries_o),
    .img_req_o(img_req_o), .img_addr_o(img_addr_o),
    .img_vld_i(img_vld_i), .img_data_i(img_data_i),
    .mem_addr_o(mem_addr_o), .mem_data_o(mem_data_o), .mem_drive_o(mem_drive_o),
    .mem_data_i(mem_data_i), .mem_ce_n_o(mem_ce_n_o), .mem_oe_n_o(mem_oe_n_o)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  typedef struct { int addr; int width; logic [7:0] data; } pulse_t;
  pulse_t exp_q[$];
  int     req_q[$];
  int     need_map[int];
  int     pulse_cnt[int];
  int     stall_cfg = 0;
  bit     exp_fail = 0;
  int     exp_fail_addr = 0;

  function automatic logic [7:0] img_of(int a);
    return 8'(a) ^ 8'h3C ^ 8'(a >>> 8);
  endfunction

  function automatic int need_of(int a);
    return need_map.exists(a) ? need_map[a] : 1;
  endfunction

  // Monitor and memory/image models, all on the falling edge.
  bit in_pulse = 0;
  int pw = 0, paddr = 0;
  logic [7:0] pdata = '0;
  bit hold_arm = 0;
  int hold_cnt = 0;
  int su_cnt = 0, su_addr = 0;
  logic [7:0] su_data = '0;
  bit oe_low = 0;
  int oe_w = 0;
  bit rec_arm = 0;
  int rec_cnt = 0;
  int stall_left = 0;
  int viol_ceoe = 0, viol_busread = 0, viol_reqce = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      in_pulse = 0; hold_arm = 0; oe_low = 0; rec_arm = 0; su_cnt = 0;
      img_vld_i = 0; mem_data_i = '0;
    end else begin
      if (!mem_ce_n_o && !mem_oe_n_o) viol_ceoe++;
      if (!mem_oe_n_o && mem_drive_o) viol_busread++;
      if (img_req_o && !mem_ce_n_o) viol_reqce++;

      // setup window tracking (R5)
      if (mem_drive_o && int'(mem_addr_o) == su_addr && mem_data_o == su_data) su_cnt++;
      else su_cnt = mem_drive_o ? 1 : 0;
      su_addr = int'(mem_addr_o);
      su_data = mem_data_o;

      // program pulses against the scoreboard
      if (!mem_ce_n_o) begin
        if (!in_pulse) begin
          in_pulse = 1; pw = 0; paddr = int'(mem_addr_o); pdata = mem_data_o;
          chk(su_cnt > SU, "R5", "setup samples before CE fall", su_cnt - 1, SU);
        end
        pw++;
      end else if (in_pulse) begin
        in_pulse = 0;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R7", "unexpected pulse at address", paddr, -1);
        end else begin
          pulse_t e;
          e = exp_q.pop_front();
          chk(paddr == e.addr, "R9", "pulse address", paddr, e.addr);
          chk(pw == e.width, (e.width == K_MS) ? "R4" : "R8", "pulse width", pw, e.width);
          chk(pdata == e.data, "R4", "pulse data", pdata, e.data);
        end
        pulse_cnt[paddr] = pulse_cnt.exists(paddr) ? pulse_cnt[paddr] + 1 : 1;
        hold_arm = 1; hold_cnt = 0;
      end
      if (hold_arm) begin
        if (mem_drive_o && int'(mem_addr_o) == paddr && mem_data_o == pdata) hold_cnt++;
        else begin
          chk(hold_cnt >= SU, "R5", "hold samples after CE rise", hold_cnt, SU);
          hold_arm = 0;
        end
      end

      // verify read window (R6)
      if (!mem_oe_n_o) begin
        if (!oe_low) begin oe_low = 1; oe_w = 0; end
        oe_w++;
      end else if (oe_low) begin
        oe_low = 0;
        chk(oe_w == ACC, "R6", "OE low width", oe_w, ACC);
        rec_arm = 1; rec_cnt = 0;
      end
      if (rec_arm && mem_oe_n_o) begin
        if (mem_drive_o) begin
          chk(rec_cnt >= ACC, "R6", "float before bus driven again", rec_cnt, ACC);
          rec_arm = 0;
        end else rec_cnt++;
      end

      // image source (R3)
      if (img_req_o) begin
        if (!img_vld_i) begin
          if (stall_left > 0) stall_left--;
          else begin
            img_vld_i = 1;
            img_data_i = img_of(int'(img_addr_o));
            if (req_q.size() == 0)
              chk(1'b0, "R3", "unexpected image request", int'(img_addr_o), -1);
            else begin
              int ea;
              ea = req_q.pop_front();
              chk(int'(img_addr_o) == ea, "R3", "image request address", int'(img_addr_o), ea);
            end
          end
        end
      end else begin
        img_vld_i = 0;
        stall_left = stall_cfg;
      end

      // memory read model: right byte only after enough pulses
      if (!mem_oe_n_o) begin
        int a, n;
        a = int'(mem_addr_o);
        n = pulse_cnt.exists(a) ? pulse_cnt[a] : 0;
        mem_data_i = (n >= need_of(a)) ? img_of(a) : (img_of(a) ^ 8'h01);
      end else mem_data_i = 8'h00;
    end
  end

  // Driver: push the expected items and start the job.
  task automatic start_run(input int first, input int last, input int stall);
    stall_cfg = stall;
    exp_fail = 0;
    for (int a = first; a <= last; a++) begin
      int n, t;
      n = need_of(a);
      t = (n > MAXT) ? MAXT : n;
      req_q.push_back(a);
      for (int k = 0; k < t; k++) exp_q.push_back('{a, K_MS, img_of(a)});
      if (n > MAXT) begin
        exp_fail = 1; exp_fail_addr = a;
        break;
      end
      exp_q.push_back('{a, 3 * n * K_MS, img_of(a)});
    end
    @(negedge clk);
    first_addr_i = AW'(first);
    last_addr_i  = AW'(last);
    start_i = 1;
    @(negedge clk);
    start_i = 0;
    chk(busy_o == 1'b1, "R2", "busy after accepted start", busy_o, 1);
    chk(done_o == 1'b0 && fail_o == 1'b0, "R2", "status cleared on start", {done_o, fail_o}, 0);
  endtask

  task automatic wait_run();
    while (busy_o) @(negedge clk);
    chk(done_o == !exp_fail, "R9", "done flag", done_o, !exp_fail);
    chk(fail_o == exp_fail, "R10", "fail flag", fail_o, exp_fail);
    if (exp_fail) begin
      chk(int'(fail_addr_o) == exp_fail_addr, "R10", "fail address", fail_addr_o, exp_fail_addr);
      chk(int'(fail_tries_o) == MAXT, "R10", "fail attempt count", fail_tries_o, MAXT);
    end
    chk(exp_q.size() == 0, "R7", "expected pulses not seen", exp_q.size(), 0);
    chk(req_q.size() == 0, "R3", "expected requests not seen", req_q.size(), 0);
    chk(mem_ce_n_o && mem_oe_n_o && !mem_drive_o && !img_req_o, "R1", "idle pin state",
        {mem_ce_n_o, mem_oe_n_o, mem_drive_o, img_req_o}, 4'b1100);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL R9 watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    need_map[32'h10] = 1;  need_map[32'h11] = 2;
    need_map[32'h12] = 3;  need_map[32'h13] = 1;
    need_map[32'h7FFF] = 25;
    need_map[32'h300] = 26;
    need_map[32'h100] = 2; need_map[32'h101] = 30;

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk(!busy_o && !done_o && !fail_o && !img_req_o, "R1", "reset status",
        {busy_o, done_o, fail_o, img_req_o}, 0);
    chk(mem_ce_n_o && mem_oe_n_o && !mem_drive_o, "R1", "reset memory pins",
        {mem_ce_n_o, mem_oe_n_o, mem_drive_o}, 3'b110);

    // Mixed attempt counts; a second start mid-job must be ignored (R2).
    start_run(32'h10, 32'h13, 0);
    repeat (40) @(negedge clk);
    first_addr_i = AW'(32'h200);
    last_addr_i  = AW'(32'h200);
    start_i = 1;
    @(negedge clk);
    start_i = 0;
    chk(busy_o == 1'b1, "R2", "busy kept during ignored start", busy_o, 1);
    wait_run();
    repeat (20) @(negedge clk);
    chk(done_o == 1'b1 && !busy_o, "R9", "done held while idle", done_o, 1);

    // Top address, single location, 25 attempts and longest over-burn (R8).
    start_run(32'h7FFF, 32'h7FFF, 3);
    wait_run();

    // Cell that never verifies: stop after the limit, next location untouched (R10).
    start_run(32'h300, 32'h301, 0);
    wait_run();
    repeat (10) @(negedge clk);
    chk(fail_o == 1'b1 && !img_req_o, "R10", "fail held, no further request", fail_o, 1);

    // Failure in mid-range after a good location, with fetch stalls (R3, R10).
    start_run(32'h100, 32'h102, 5);
    wait_run();

    // A new job after a failure runs normally.
    start_run(32'h20, 32'h21, 1);
    wait_run();

    chk(viol_ceoe == 0, "R11", "CE and OE low together", viol_ceoe, 0);
    chk(viol_busread == 0, "R11", "bus driven during read", viol_busread, 0);
    chk(viol_reqce == 0, "R3", "pulse while request open", viol_reqce, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule